// File: doc/BRIEF.md
# Idle and Power-Down Mode Controller

This block owns the 8-bit power control register of a small microcontroller and turns its mode bits into clock enables. Software writes the register over a byte-wide special-function-register port at address 87h. Setting the idle bit stops the CPU clock and leaves the peripheral clock (interrupt, serial, timers) running. Setting the power-down bit stops every clock by dropping the oscillator-run enable.

Idle ends when the interrupt controller reports a pending enabled interrupt: hardware clears the idle bit and keeps the two general-purpose flags. Power-down ends only by a hardware reset. In normal running and in idle, the reset input must be held for 24 oscillator clocks before it takes effect. In power-down the reset restarts the oscillator at once and clears the register without counting. The block also outputs a park request and a park level that the bus logic uses to hold its address-latch and program-strobe pins.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After `rst_ni` is released, the register at 87h reads 00h, `cpu_clk_en_o`, `per_clk_en_o` and `osc_run_o` are 1, and `park_o` is 0. Bits 6 to 4 always read 0 and ignore writes.
- R2: A write to 87h in running mode updates bit 7 (baud doubling), bit 3 (GF1), bit 2 (GF0), bit 1 (power-down) and bit 0 (idle) on the next clock edge. Reads at 87h return the register. Writes to other addresses change nothing, and reads at other addresses return 00h.
- R3: Writing bit 0 = 1 with bit 1 = 0 enters idle on the next edge: `cpu_clk_en_o`=0, `per_clk_en_o`=1, `osc_run_o`=1, `park_o`=1, `park_level_o`=1.
- R4: A single write with bits 1 and 0 both 1 enters power-down, and bit 0 reads back 0.
- R5: In power-down with `hw_rst_i` low: `cpu_clk_en_o`=0, `per_clk_en_o`=0, `osc_run_o`=0, `park_o`=1, `park_level_o`=0. The register contents are kept.
- R6: In idle, `irq_pend_i`=1 clears bit 0 on the next edge and leaves bits 7, 3 and 2 unchanged. In running mode `irq_pend_i` has no effect.
- R7: In power-down, `irq_pend_i` has no effect. SFR writes are ignored while in idle or in power-down.
- R8: Outside power-down, `hw_rst_i` high at 24 consecutive clock edges clears the register two edges after the 24th high sample. A pulse of 23 edges has no effect.
- R9: In power-down, `hw_rst_i`=1 drives `osc_run_o` high without waiting for a clock, and the register is cleared by the second clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| hw_rst_i | input | 1 | External reset pin, active high |
| sfr_addr_i | input | 8 | SFR address |
| sfr_wr_i | input | 1 | SFR write strobe |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | SFR read data |
| irq_pend_i | input | 1 | An enabled interrupt is pending |
| cpu_clk_en_o | output | 1 | CPU core clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_run_o | output | 1 | Oscillator run enable |
| park_o | output | 1 | Low-power mode active, hold bus strobes |
| park_level_o | output | 1 | Level for parked strobes (1 idle, 0 power-down) |

## Verification
Register writes, interrupt exits and mode entries take effect at the first clock edge after the stimulus. The bench drives inputs on falling edges and samples at the next falling edge. Read data is combinational, so it is sampled 1 ns after the address changes. A qualified reset clears the register at the second edge after the 24th high sample; the bench waits three falling edges after releasing the pin before it checks. Power-down reset is checked twice: the oscillator enable 1 ns after the pin rises, and the register after two edges.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef struct packed {
    logic smod;
    logic gf1;
    logic gf0;
    logic pd;
    logic idl;
  } pmc_reg_t;

  function automatic logic [7:0] pmc_pack(pmc_reg_t r);
    return {r.smod, 3'b000, r.gf1, r.gf0, r.pd, r.idl};
  endfunction

  // power-down wins over idle when both are written
  function automatic pmc_reg_t pmc_from_wr(logic [7:0] d);
    pmc_reg_t r;
    r.smod = d[7];
    r.gf1  = d[3];
    r.gf0  = d[2];
    r.pd   = d[1];
    r.idl  = d[0] & ~d[1];
    return r;
  endfunction
endpackage

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
  parameter int unsigned RST_CYCLES = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_rst_i,
  input  logic pd_i,
  output logic int_rst_o
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(RST_CYCLES);

  logic          rst_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      rst_q <= hw_rst_i;
      if (!rst_q)           cnt_q <= '0;
      else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  // count bypassed in power-down: the oscillator restarts from the pin
  assign int_rst_o = (cnt_q == CMAX) | (pd_i & rst_q);

  p_qual_hist_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CMAX) |-> $past(rst_q));
endmodule

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
  import pmc_pkg::*;
#(
  parameter logic [7:0] SFR_ADDR = 8'h87
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       int_rst_i,
  input  logic [7:0] sfr_addr_i,
  input  logic       sfr_wr_i,
  input  logic [7:0] sfr_wdata_i,
  input  logic       irq_pend_i,
  output pmc_reg_t   reg_o,
  output logic [7:0] rdata_o
);
  pmc_reg_t reg_q;
  logic     hit, wr_ok;

  assign hit   = (sfr_addr_i == SFR_ADDR);
  assign wr_ok = sfr_wr_i & hit & ~reg_q.idl & ~reg_q.pd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               reg_q <= '0;
    else if (int_rst_i)        reg_q <= '0;
    else if (wr_ok)            reg_q <= pmc_from_wr(sfr_wdata_i);
    else if (reg_q.idl && irq_pend_i) reg_q.idl <= 1'b0;
  end

  assign reg_o   = reg_q;
  assign rdata_o = hit ? pmc_pack(reg_q) : 8'h00;

  p_both_pd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && sfr_wdata_i[1:0] == 2'b11 && !int_rst_i) |=> (reg_q.pd && !reg_q.idl));
  p_irq_exit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_q.idl && irq_pend_i && !int_rst_i) |=> !reg_q.idl);
  p_flags_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ok && !int_rst_i) |=> $stable({reg_q.smod, reg_q.gf1, reg_q.gf0}));
  p_pd_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_q.pd && !int_rst_i) |=> reg_q.pd);
  p_one_mode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_q.pd, reg_q.idl}));
endmodule

// File: rtl/pmc_clk_gate.sv
module pmc_clk_gate (
  input  logic idl_i,
  input  logic pd_i,
  input  logic hw_rst_i,
  output logic cpu_clk_en_o,
  output logic per_clk_en_o,
  output logic osc_run_o,
  output logic park_o,
  output logic park_level_o
);
  assign cpu_clk_en_o = ~idl_i & ~pd_i;
  assign per_clk_en_o = ~pd_i;
  assign osc_run_o    = ~pd_i | hw_rst_i;
  assign park_o       = idl_i | pd_i;
  assign park_level_o = idl_i & ~pd_i;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter logic [7:0]  SFR_ADDR   = 8'h87,
  parameter int unsigned RST_CYCLES = 24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hw_rst_i,
  input  logic [7:0] sfr_addr_i,
  input  logic       sfr_wr_i,
  input  logic [7:0] sfr_wdata_i,
  output logic [7:0] sfr_rdata_o,
  input  logic       irq_pend_i,
  output logic       cpu_clk_en_o,
  output logic       per_clk_en_o,
  output logic       osc_run_o,
  output logic       park_o,
  output logic       park_level_o
);
  pmc_reg_t pmc;
  logic     int_rst;

  pmc_rst_qual #(.RST_CYCLES(RST_CYCLES)) u_qual (
    .clk_i, .rst_ni, .hw_rst_i, .pd_i(pmc.pd), .int_rst_o(int_rst)
  );

  pmc_ctrl_reg #(.SFR_ADDR(SFR_ADDR)) u_reg (
    .clk_i, .rst_ni, .int_rst_i(int_rst), .sfr_addr_i, .sfr_wr_i,
    .sfr_wdata_i, .irq_pend_i, .reg_o(pmc), .rdata_o(sfr_rdata_o)
  );

  pmc_clk_gate u_gate (
    .idl_i(pmc.idl), .pd_i(pmc.pd), .hw_rst_i, .cpu_clk_en_o,
    .per_clk_en_o, .osc_run_o, .park_o, .park_level_o
  );

  p_idle_clk_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_wr_i && sfr_addr_i == SFR_ADDR && sfr_wdata_i[1:0] == 2'b01
     && cpu_clk_en_o && !int_rst) |=> (!cpu_clk_en_o && per_clk_en_o));
endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  logic       clk_i = 1'b0, rst_ni = 1'b0, hw_rst_i = 1'b0;
  logic [7:0] sfr_addr_i = 8'h00, sfr_wdata_i = 8'h00, sfr_rdata_o;
  logic       sfr_wr_i = 1'b0, irq_pend_i = 1'b0;
  logic       cpu_clk_en_o, per_clk_en_o, osc_run_o, park_o, park_level_o;
  int total = 0, bad = 0;
  logic [7:0] exp_reg = 8'h00;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pwr_mode_ctrl u_dut (.*);

  function automatic logic [7:0] wr_model(logic [7:0] d);
    logic [7:0] r = d & 8'h8F;
    if (r[1]) r[0] = 1'b0;
    return r;
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
    sfr_addr_i = a; #1;
    chk(req, sfr_rdata_o, exp);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i); sfr_addr_i = a; sfr_wdata_i = d; sfr_wr_i = 1'b1;
    @(negedge clk_i); sfr_wr_i = 1'b0;
  endtask

  task automatic outs(string req, logic [4:0] exp);
    chk(req, {3'b0, cpu_clk_en_o, per_clk_en_o, osc_run_o, park_o, park_level_o},
        {3'b0, exp});
  endtask

  task automatic pin_rst(int n);
    @(negedge clk_i); hw_rst_i = 1'b1;
    repeat (n) @(negedge clk_i);
    hw_rst_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd_chk("R1 reset value", 8'h87, 8'h00);
    outs("R1 reset outputs", 5'b11100);

    // R2 / R1: random running-mode traffic, mode bits masked off
    for (int i = 0; i < 60; i++) begin
      logic [7:0] a = ($urandom % 3 == 0) ? 8'($urandom) : 8'h87;
      logic [7:0] d = 8'($urandom) & 8'hFC;
      irq_pend_i = 1'($urandom);
      wr(a, d);
      if (a == 8'h87) exp_reg = wr_model(d);
      rd_chk("R2 random write", 8'h87, exp_reg);
      if (a != 8'h87) rd_chk("R2 other address read", a, 8'h00);
    end
    irq_pend_i = 1'b0;
    wr(8'h87, 8'h70); exp_reg = 8'h00;
    rd_chk("R1 reserved bits", 8'h87, 8'h00);

    // R3 idle entry, R7 write ignored, R6 irq exit
    wr(8'h87, 8'h8D); exp_reg = 8'h8D;
    outs("R3 idle outputs", 5'b01111);
    rd_chk("R3 idle readback", 8'h87, 8'h8D);
    wr(8'h87, 8'h04);
    rd_chk("R7 write ignored in idle", 8'h87, 8'h8D);
    @(negedge clk_i); irq_pend_i = 1'b1;
    @(negedge clk_i); irq_pend_i = 1'b0;
    rd_chk("R6 irq clears idle keeps flags", 8'h87, 8'h8C);
    outs("R6 running after irq", 5'b11100);

    // R4 both bits, R5 outputs, R7 irq and writes ignored
    wr(8'h87, 8'h0B);
    rd_chk("R4 both bits to pd", 8'h87, 8'h0A);
    outs("R5 pd outputs", 5'b00010);
    @(negedge clk_i); irq_pend_i = 1'b1;
    repeat (2) @(negedge clk_i); irq_pend_i = 1'b0;
    rd_chk("R7 irq ignored in pd", 8'h87, 8'h0A);
    wr(8'h87, 8'h00);
    rd_chk("R7 write ignored in pd", 8'h87, 8'h0A);

    // R9 pd reset bypass
    @(negedge clk_i); hw_rst_i = 1'b1; #1;
    chk("R9 osc restart", {7'b0, osc_run_o}, 8'h01);
    repeat (2) @(negedge clk_i);
    rd_chk("R9 pd reset clears", 8'h87, 8'h00);
    hw_rst_i = 1'b0;
    repeat (3) @(negedge clk_i);

    // R8 qualified reset boundary
    wr(8'h87, 8'h8C);
    pin_rst(23);
    rd_chk("R8 short pulse ignored", 8'h87, 8'h8C);
    pin_rst(24);
    rd_chk("R8 qualified reset", 8'h87, 8'h00);
    wr(8'h87, 8'h05);
    pin_rst(30);
    rd_chk("R8 reset ends idle", 8'h87, 8'h00);
    outs("R8 outputs after reset", 5'b11100);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule